// File: doc/BRIEF.md
# Serial Boot Image Sequencer with Extension Read-Out

After every reset this block streams a fixed-format boot image, one bit at a time, into the serial load port of a processor's instruction cache. The image is held in a bit-addressed ROM as a series of cache-block records. Each record holds a tag, an address-space number, an address-space-match bit, a valid bit, a branch-history field and eight data longwords. The sequencer walks the blocks in ascending order. Within each block it emits the fields in a fixed interleaved order, and within each field it sends the most significant bit first. A divided serial clock paces the stream, and the loader samples each bit on the rising edge of that clock.

Once the last bit of the final block has gone out, the block raises a load-done flag and switches the same ROM read port over to an extension image. Software then reads that image one bit at a time. Each bit appears on the receive output a programmable number of clock cycles after the previous step. The first bit follows the end of the bulk load, and each later bit follows a low-to-high transition of a software-driven transmit bit. Transmit transitions that come closer together than that same interval set a sticky timing-error flag. A rising edge taken while the final extension bit is being presented locks the read-out until the next reset.

Top module: `sbl_boot_seq`

## Requirements
- R1: While `rst` is high, `sClk`, `sData`, `rcvBit`, `bitValid`, `loadDone`, `extDone`, `timingErr` and `romSel` are all 0. A complete bulk load starts again every time `rst` is released.
- R2: The bulk load visits blocks 0 to NUM_BLOCKS-1 in ascending order. Inside a block it emits the fields in this order: LW0, LW2, LW4, LW6, TAG, ASN, ASM, VALID, LW1, LW3, LW5, LW7, BRHIST.
- R3: Block b's record starts at ROM bit address b*REC_BITS, where REC_BITS = TAG_W+ASN_W+2+BH_W+8*LW_W. Inside the record the fields are stored from offset 0 in the order TAG, ASN, ASM, VALID, BRHIST, LW0..LW7, and bit k of a field sits at field base + k. Each field is sent from k = width-1 down to k = 0. During the bulk load `romSel` is 0.
- R4: Each serial bit lasts 2*HALF_DIV clock cycles. `sClk` is low for the first half and high for the second, and `sData` does not change while `sClk` is high.
- R5: `loadDone` rises within HALF_DIV cycles of the final bit's rising `sClk` edge. After that, `sClk` stays low and `romSel` is 1.
- R6: `bitValid` rises exactly DELAY_CYC cycles after `loadDone` rises, with `rcvBit` equal to extension bit 0.
- R7: In the extension phase, a 0→1 change of `xmitBit` seen at a clock edge clears `bitValid` at that edge and advances `romAddr` by one. DELAY_CYC cycles later, `bitValid` returns to 1 with `rcvBit` set to the extension bit at the new address.
- R8: A 1→0 change of `xmitBit` does not move `romAddr` and does not clear `bitValid`.
- R9: Changes of `xmitBit` during the bulk load neither set `timingErr` nor alter the serial stream.
- R10: In the extension phase, two `xmitBit` changes in either direction fewer than DELAY_CYC cycles apart set `timingErr`, which stays 1 until reset. A spacing of exactly DELAY_CYC cycles is legal.
- R11: A 0→1 change of `xmitBit` while `romAddr` is EXT_BITS-1 sets `extDone`. After that, `bitValid` and `rcvBit` stay 0 and `romAddr` does not move until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| xmitBit | input | 1 | Software transmit bit that steps the extension read-out |
| romData | input | 1 | ROM bit at `romAddr` in the image chosen by `romSel` |
| romAddr | output | ADDR_W | ROM bit address |
| romSel | output | 1 | 0 selects the boot image, 1 selects the extension image |
| sClk | output | 1 | Serial load clock to the cache loader |
| sData | output | 1 | Serial load data |
| rcvBit | output | 1 | Current extension bit |
| bitValid | output | 1 | `rcvBit` holds the bit addressed after the delay |
| loadDone | output | 1 | Bulk load finished |
| extDone | output | 1 | Extension read-out locked |
| timingErr | output | 1 | Sticky transmit-spacing violation |

## Verification
The bulk stream is checked against a ROM whose bits are a scrambled function of the address. Because of that, a wrong field order, a reversed bit order inside a field or a wrong record stride each produce mismatches in a particular block, and these show up separately from a wrong bit count or a wrong bit period. The extension read-out is driven with rise and fall spacings of exactly DELAY_CYC and longer. This separates correct stepping on rising edges from a design that also steps on falling edges, and it shows that legal spacing at the threshold does not raise the error flag. Directed cases apply short spacing, transmit toggles during the bulk load, a rising edge at the final extension bit, and a reset in the middle of the extension phase.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

  localparam int NUM_FIELDS = 13;

  typedef enum logic [3:0] {
    F_TAG, F_ASN, F_ASM, F_VLD, F_BH,
    F_LW0, F_LW1, F_LW2, F_LW3, F_LW4, F_LW5, F_LW6, F_LW7
  } fieldId_e;

  typedef enum logic [1:0] {S_LOAD, S_WAIT, S_READY, S_LOCK} seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchLoad;  // capture boot-image bit into serial data register
    logic advLoad;    // step block/field/bit counters
    logic selExt;     // route extension address to the ROM port
    logic capExt;     // capture extension bit into receive register
    logic advExt;     // step extension address
    logic clearRcv;   // zero the receive register (lockout)
  } dpCtl_t;

  // shift position within a block -> field
  function automatic fieldId_e shiftField(input logic [3:0] pos);
    case (pos)
      4'd0:    return F_LW0;
      4'd1:    return F_LW2;
      4'd2:    return F_LW4;
      4'd3:    return F_LW6;
      4'd4:    return F_TAG;
      4'd5:    return F_ASN;
      4'd6:    return F_ASM;
      4'd7:    return F_VLD;
      4'd8:    return F_LW1;
      4'd9:    return F_LW3;
      4'd10:   return F_LW5;
      4'd11:   return F_LW7;
      default: return F_BH;
    endcase
  endfunction

endpackage

// File: rtl/sbl_datapath.sv
module sbl_datapath
  import sbl_pkg::*;
#(
  parameter int NUM_BLOCKS = 256,
  parameter int TAG_W      = 21,
  parameter int ASN_W      = 6,
  parameter int BH_W       = 8,
  parameter int LW_W       = 32,
  parameter int ADDR_W     = 17,
  parameter int EXT_BITS   = 131072
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic              romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              sData,
  output logic              rcvBit,
  output logic              lastLoadBit,
  output logic              lastExtBit
);

  localparam int LW_BASE  = TAG_W + ASN_W + 2 + BH_W;
  localparam int REC_BITS = LW_BASE + 8 * LW_W;
  localparam int BLK_W    = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int FB_W     = $clog2(TAG_W + ASN_W + BH_W + LW_W + 1);
  localparam logic [3:0] LAST_POS = 4'(NUM_FIELDS - 1);

  function automatic int fieldWidth(input fieldId_e f);
    case (f)
      F_TAG:        return TAG_W;
      F_ASN:        return ASN_W;
      F_ASM, F_VLD: return 1;
      F_BH:         return BH_W;
      default:      return LW_W;
    endcase
  endfunction

  function automatic int fieldBase(input fieldId_e f);
    case (f)
      F_TAG:   return 0;
      F_ASN:   return TAG_W;
      F_ASM:   return TAG_W + ASN_W;
      F_VLD:   return TAG_W + ASN_W + 1;
      F_BH:    return TAG_W + ASN_W + 2;
      default: return LW_BASE + (int'(f) - int'(F_LW0)) * LW_W;
    endcase
  endfunction

  logic [BLK_W-1:0]  blockIdx;
  logic [3:0]        shiftPos;
  logic [FB_W-1:0]   bitIdx;
  logic [ADDR_W-1:0] extAddr;
  logic [ADDR_W-1:0] loadAddr;
  logic              sDataQ;
  logic              rcvQ;
  fieldId_e          curField;
  fieldId_e          nextField;

  always_comb begin
    curField  = shiftField(shiftPos);
    nextField = shiftField((shiftPos == LAST_POS) ? 4'd0 : shiftPos + 4'd1);
    loadAddr  = ADDR_W'(int'(blockIdx) * REC_BITS + fieldBase(curField) + int'(bitIdx));
    romAddr   = ctl.selExt ? extAddr : loadAddr;
  end

  assign lastLoadBit = (blockIdx == BLK_W'(NUM_BLOCKS - 1)) && (shiftPos == LAST_POS) &&
                       (bitIdx == '0);
  assign lastExtBit  = (extAddr == ADDR_W'(EXT_BITS - 1));
  assign sData       = sDataQ;
  assign rcvBit      = rcvQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      blockIdx <= '0;
      shiftPos <= '0;
      bitIdx   <= FB_W'(fieldWidth(shiftField(4'd0)) - 1);
      extAddr  <= '0;
      sDataQ   <= 1'b0;
      rcvQ     <= 1'b0;
    end else begin
      if (ctl.latchLoad) sDataQ <= romData;
      if (ctl.advLoad) begin
        if (bitIdx == '0) begin
          if (shiftPos == LAST_POS) begin
            shiftPos <= '0;
            blockIdx <= blockIdx + 1'b1;
          end else begin
            shiftPos <= shiftPos + 4'd1;
          end
          bitIdx <= FB_W'(fieldWidth(nextField) - 1);
        end else begin
          bitIdx <= bitIdx - 1'b1;
        end
      end
      if (ctl.advExt) extAddr <= extAddr + ADDR_W'(1);
      if (ctl.capExt)        rcvQ <= romData;
      else if (ctl.clearRcv) rcvQ <= 1'b0;
    end
  end

  // R2: block index never leaves the image
  assert_block_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(blockIdx) < NUM_BLOCKS);

  // R7: extension address only ever steps by one
  assert_ext_step_R7: assert property (@(posedge clk) disable iff (rst)
    (extAddr != $past(extAddr)) |-> (extAddr == $past(extAddr) + ADDR_W'(1)));

endmodule

// File: rtl/sbl_control.sv
module sbl_control
  import sbl_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int DELAY_CYC = 100
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   xmitBit,
  input  logic   lastLoadBit,
  input  logic   lastExtBit,
  output dpCtl_t ctl,
  output logic   sClk,
  output logic   bitValid,
  output logic   loadDone,
  output logic   extDone,
  output logic   timingErr
);

  localparam int PH_W  = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
  localparam int DLY_W = $clog2(DELAY_CYC + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(2 * HALF_DIV - 1);
  localparam logic [PH_W-1:0]  PH_HIGH = PH_W'(HALF_DIV);
  localparam logic [DLY_W-1:0] DLY_MAX = DLY_W'(DELAY_CYC);
  localparam logic [DLY_W-1:0] DLY_END = DLY_W'(DELAY_CYC - 1);

  seqState_e       state;
  logic [PH_W-1:0] ph;
  logic [DLY_W-1:0] dlyCnt;
  logic [DLY_W-1:0] gapCnt;
  logic            xmitQ;
  logic            bitValidQ;
  logic            timingErrQ;
  logic            xmitRise;
  logic            xmitEdge;
  logic            inExt;
  logic            stepping;
  logic            phEnd;
  logic            dlyDone;

  assign xmitRise = xmitBit & ~xmitQ;
  assign xmitEdge = xmitBit ^ xmitQ;
  assign inExt    = (state != S_LOAD);
  assign stepping = (state == S_WAIT) || (state == S_READY);
  assign phEnd    = (ph == PH_LAST);
  assign dlyDone  = (dlyCnt == DLY_END);

  always_comb begin
    ctl           = '0;
    ctl.selExt    = inExt;
    ctl.latchLoad = (state == S_LOAD) && (ph == '0);
    ctl.advLoad   = (state == S_LOAD) && phEnd && !lastLoadBit;
    ctl.capExt    = (state == S_WAIT) && !xmitRise && dlyDone;
    ctl.advExt    = stepping && xmitRise && !lastExtBit;
    ctl.clearRcv  = stepping && xmitRise && lastExtBit;
  end

  assign sClk      = (state == S_LOAD) && (ph >= PH_HIGH);
  assign bitValid  = bitValidQ;
  assign loadDone  = inExt;
  assign extDone   = (state == S_LOCK);
  assign timingErr = timingErrQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_LOAD;
      ph         <= '0;
      dlyCnt     <= '0;
      gapCnt     <= DLY_MAX;
      xmitQ      <= 1'b0;
      bitValidQ  <= 1'b0;
      timingErrQ <= 1'b0;
    end else begin
      xmitQ <= xmitBit;
      case (state)
        S_LOAD: begin
          ph <= phEnd ? '0 : ph + 1'b1;
          if (phEnd && lastLoadBit) begin
            state  <= S_WAIT;
            dlyCnt <= '0;
          end
        end
        S_WAIT, S_READY: begin
          if (xmitRise) begin
            bitValidQ <= 1'b0;
            dlyCnt    <= '0;
            state     <= lastExtBit ? S_LOCK : S_WAIT;
          end else if (state == S_WAIT) begin
            if (dlyDone) begin
              bitValidQ <= 1'b1;
              state     <= S_READY;
            end else begin
              dlyCnt <= dlyCnt + 1'b1;
            end
          end
        end
        default: ;
      endcase
      // transition spacing watch, extension phase only
      if (inExt) begin
        if (xmitEdge) begin
          if (gapCnt < DLY_MAX) timingErrQ <= 1'b1;
          gapCnt <= DLY_W'(1);
        end else if (gapCnt < DLY_MAX) begin
          gapCnt <= gapCnt + 1'b1;
        end
      end
    end
  end

  // R5: no serial clock pulses after the bulk load
  assert_sclk_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    loadDone |-> !sClk);

  // R9: transmit activity during the load never flags
  assert_no_err_in_load_R9: assert property (@(posedge clk) disable iff (rst)
    !loadDone |-> !timingErr);

  // R10: error flag is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    timingErr |=> timingErr);

  // R7: a rising transmit edge invalidates the presented bit
  assert_valid_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (inExt && xmitRise) |=> !bitValid);

  // R11: lockout is permanent until reset
  assert_lock_hold_R11: assert property (@(posedge clk) disable iff (rst)
    extDone |=> extDone);

endmodule

// File: rtl/sbl_boot_seq.sv
module sbl_boot_seq
  import sbl_pkg::*;
#(
  parameter int NUM_BLOCKS = 256,
  parameter int TAG_W      = 21,
  parameter int ASN_W      = 6,
  parameter int BH_W       = 8,
  parameter int LW_W       = 32,
  parameter int ADDR_W     = 17,
  parameter int EXT_BITS   = 131072,
  parameter int HALF_DIV   = 4,
  parameter int DELAY_CYC  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xmitBit,
  input  logic              romData,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romSel,
  output logic              sClk,
  output logic              sData,
  output logic              rcvBit,
  output logic              bitValid,
  output logic              loadDone,
  output logic              extDone,
  output logic              timingErr
);

  dpCtl_t ctl;
  logic   lastLoadBit;
  logic   lastExtBit;

  sbl_control #(
    .HALF_DIV (HALF_DIV),
    .DELAY_CYC(DELAY_CYC)
  ) control_i (
    .clk        (clk),
    .rst        (rst),
    .xmitBit    (xmitBit),
    .lastLoadBit(lastLoadBit),
    .lastExtBit (lastExtBit),
    .ctl        (ctl),
    .sClk       (sClk),
    .bitValid   (bitValid),
    .loadDone   (loadDone),
    .extDone    (extDone),
    .timingErr  (timingErr)
  );

  sbl_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .TAG_W     (TAG_W),
    .ASN_W     (ASN_W),
    .BH_W      (BH_W),
    .LW_W      (LW_W),
    .ADDR_W    (ADDR_W),
    .EXT_BITS  (EXT_BITS)
  ) datapath_i (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .romData    (romData),
    .romAddr    (romAddr),
    .sData      (sData),
    .rcvBit     (rcvBit),
    .lastLoadBit(lastLoadBit),
    .lastExtBit (lastExtBit)
  );

  assign romSel = ctl.selExt;

  // R3: boot image selected for the whole bulk load
  assert_boot_sel_R3: assert property (@(posedge clk) disable iff (rst)
    !loadDone |-> !romSel);

  // R4: serial data held while the serial clock is high
  assert_sdata_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (sClk && $past(sClk)) |-> $stable(sData));

  // R11: nothing presented once locked
  assert_locked_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    extDone |-> (!bitValid && !rcvBit));

endmodule

// File: tb/sbl_boot_seq_tb.sv
`timescale 1ns/100ps
module sbl_boot_seq_tb_top;

  localparam int NB    = 3;
  localparam int TW    = 5;
  localparam int AW    = 3;
  localparam int BW    = 2;
  localparam int LW    = 4;
  localparam int ADW   = 10;
  localparam int EXTN  = 6;
  localparam int HD    = 2;
  localparam int DLY   = 10;
  localparam int LWB   = TW + AW + 2 + BW;
  localparam int REC   = LWB + 8 * LW;
  localparam int TOTAL = NB * REC;

  // shift order within a block and where each field lives in the record
  localparam int SH_BASE [13] = '{LWB, LWB + 2*LW, LWB + 4*LW, LWB + 6*LW, 0, TW, TW + AW,
                                  TW + AW + 1, LWB + LW, LWB + 3*LW, LWB + 5*LW, LWB + 7*LW,
                                  TW + AW + 2};
  localparam int SH_W [13]    = '{LW, LW, LW, LW, TW, AW, 1, 1, LW, LW, LW, LW, BW};

  typedef struct packed { int lowCyc; int highCyc; } vec_t;
  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{'{10, 11}, '{10, 15}, '{25, 11}, '{13, 20}, '{10, 11}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xmitBit = 1'b0;
  logic romData;
  logic [ADW-1:0] romAddr;
  logic romSel, sClk, sData, rcvBit, bitValid, loadDone, extDone, timingErr;

  always #2.5 clk = ~clk;

  sbl_boot_seq #(
    .NUM_BLOCKS(NB), .TAG_W(TW), .ASN_W(AW), .BH_W(BW), .LW_W(LW),
    .ADDR_W(ADW), .EXT_BITS(EXTN), .HALF_DIV(HD), .DELAY_CYC(DLY)
  ) dut_i (
    .clk(clk), .rst(rst), .xmitBit(xmitBit), .romData(romData), .romAddr(romAddr),
    .romSel(romSel), .sClk(sClk), .sData(sData), .rcvBit(rcvBit), .bitValid(bitValid),
    .loadDone(loadDone), .extDone(extDone), .timingErr(timingErr)
  );

  function automatic logic initBit(input int a);
    int x;
    x = a * 40503 + 17;
    return x[3] ^ x[7] ^ x[11];
  endfunction

  function automatic logic extBit(input int a);
    int pat;
    pat = 32'h2D;
    return pat[a % 32];
  endfunction

  function automatic logic expBit(input int idx);
    int b, r;
    b = idx / REC;
    r = idx % REC;
    for (int s = 0; s < 13; s++) begin
      if (r < SH_W[s]) return initBit(b * REC + SH_BASE[s] + (SH_W[s] - 1 - r));
      r -= SH_W[s];
    end
    return 1'b0;
  endfunction

  always_comb romData = romSel ? extBit(int'(romAddr)) : initBit(int'(romAddr));

  // serial monitor
  logic monClear = 1'b1;
  logic capt [TOTAL];
  int monCount, badPer, unstable, cyc, lastRise;
  logic prevS, held, doneAtLast;

  always @(negedge clk) begin
    if (monClear) begin
      monCount = 0; badPer = 0; unstable = 0; cyc = 0; lastRise = -1;
      prevS = 1'b0; held = 1'b0; doneAtLast = 1'b0;
    end else begin
      cyc++;
      if (sClk && !prevS) begin
        if (lastRise >= 0 && cyc - lastRise != 2 * HD) badPer++;
        lastRise = cyc;
        if (monCount < TOTAL) capt[monCount] = sData;
        monCount++;
        held = sData;
        if (monCount == TOTAL) doneAtLast = loadDone;
      end else if (sClk && sData != held) begin
        unstable++;
      end
      prevS = sClk;
    end
  end

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkBlocks();
    for (int b = 0; b < NB; b++) begin
      int bad = 0;
      for (int i = b * REC; i < (b + 1) * REC; i++)
        if (capt[i] !== expBit(i)) bad++;
      chk(bad == 0, "R2 R3 block stream mismatches", bad, 0);
    end
  endtask

  task automatic checkResetState(input string tag);
    chk({sClk, sData, rcvBit, bitValid, loadDone, extDone, timingErr, romSel} == 8'h00,
        tag, int'({sClk, sData, rcvBit, bitValid, loadDone, extDone, timingErr, romSel}), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // ---------- run 1: reset state, bulk load ----------
    cycles(3);
    checkResetState("R1 reset outputs");
    monClear = 1'b0;
    rst = 1'b0;
    // R9: toggles with short spacing during the load
    for (int t = 0; t < 10; t++) begin
      cycles(2);
      xmitBit = ~xmitBit;
    end
    xmitBit = 1'b0;
    while (!loadDone) @(negedge clk);
    chk(monCount == TOTAL, "R4 bit count", monCount, TOTAL);
    chk(badPer == 0, "R4 bit period errors", badPer, 0);
    chk(unstable == 0, "R4 sData change while sClk high", unstable, 0);
    checkBlocks();
    chk(doneAtLast == 1'b0, "R5 loadDone at last rise", int'(doneAtLast), 0);
    chk(romSel == 1'b1, "R5 romSel after load", int'(romSel), 1);
    chk(timingErr == 1'b0, "R9 no flag from load toggles", int'(timingErr), 0);

    // R6: first extension bit
    cycles(DLY - 1);
    chk(bitValid == 1'b0, "R6 bitValid early", int'(bitValid), 0);
    cycles(1);
    chk(bitValid == 1'b1, "R6 bitValid on time", int'(bitValid), 1);
    chk(rcvBit == extBit(0), "R6 first bit", int'(rcvBit), int'(extBit(0)));
    cycles(DLY);

    // R7/R8: vector walk
    for (int i = 0; i < NV; i++) begin
      xmitBit = 1'b1;
      cycles(DLY);
      chk(bitValid == 1'b0, "R7 bitValid before delay", int'(bitValid), 0);
      cycles(1);
      chk(bitValid == 1'b1 && rcvBit == extBit(i + 1), "R7 stepped bit",
          int'({bitValid, rcvBit}), int'({1'b1, extBit(i + 1)}));
      cycles(VECS[i].highCyc - DLY - 1);
      xmitBit = 1'b0;
      cycles(VECS[i].lowCyc);
      chk(bitValid == 1'b1 && int'(romAddr) == i + 1, "R8 fall ignored",
          int'(romAddr), i + 1);
    end
    chk(timingErr == 1'b0, "R10 spacing of exactly DELAY legal", int'(timingErr), 0);

    // R11: rising edge at last bit locks
    xmitBit = 1'b1;
    cycles(1);
    chk(extDone == 1'b1 && bitValid == 1'b0 && rcvBit == 1'b0, "R11 lock on last",
        int'({extDone, bitValid, rcvBit}), 4);
    cycles(12); xmitBit = 1'b0;
    cycles(12); xmitBit = 1'b1;
    cycles(DLY + 10);
    chk(extDone && !bitValid && !rcvBit && int'(romAddr) == EXTN - 1,
        "R11 toggles after lock", int'(romAddr), EXTN - 1);

    // ---------- run 2: reset mid-extension, reload, short spacing ----------
    rst = 1'b1;
    monClear = 1'b1;
    xmitBit = 1'b0;
    cycles(3);
    checkResetState("R1 reset after lock");
    monClear = 1'b0;
    rst = 1'b0;
    while (!loadDone) @(negedge clk);
    chk(monCount == TOTAL, "R1 reload bit count", monCount, TOTAL);
    checkBlocks();
    cycles(DLY + 2);
    xmitBit = 1'b1;
    cycles(DLY - 1);
    xmitBit = 1'b0;
    cycles(2);
    chk(timingErr == 1'b1, "R10 short spacing flagged", int'(timingErr), 1);
    cycles(3 * DLY);
    chk(timingErr == 1'b1, "R10 flag sticky", int'(timingErr), 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule